// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block sits between a USB on-the-go controller core and the system interrupt controller. It latches two groups of event pulses into two 32-bit pending words. The first group holds per-endpoint events: transmit endpoints in the low half and receive endpoints in the high half. The second group holds nine core-level USB events. Each pending word has an enable mask. Software reads raw and masked views and drives a single level interrupt line.

Software never writes a pending or mask word directly. It uses write-one set and write-one clear alias offsets, so a read-modify-write race against hardware events cannot occur. The interrupt line follows an end-of-interrupt rule. Once the line has been raised, it stays quiet after it falls until software writes the end-of-interrupt offset. The handler can therefore acknowledge every source, and any event that arrives late still produces a fresh edge. A control bit returns all of this state to its reset values.

Top module: `usb_irq_wrap`

## Requirements
- R1: Byte offset 0x00 reads the nonzero constant `REV_ID` (default 0x5EC0_0102). The following offsets read zero: control 0x04, status 0x08, reserved 0x10 and 0x5C, every set/clear alias, and end-of-interrupt 0x60.
- R2: The endpoint pending word is read at 0x20. Transmit events for endpoints 0..15 map to bits 15:0, and receive events for endpoints 1..15 map to bits 31:17. Bit 16 always reads zero, even when its event input pulses.
- R3: The core pending word is read at 0x40. Core event input k sets bit 16+k for k = 0..8. Bits 15:0 and 31:25 always read zero.
- R4: The set aliases are 0x24 (endpoint pending), 0x30 (endpoint mask), 0x44 (core pending) and 0x50 (core mask). Each one sets exactly the stored bits written as 1 and leaves the bits written as 0 unchanged. The masks read back at 0x2C (endpoint) and 0x4C (core).
- R5: The clear aliases are 0x28, 0x34, 0x48 and 0x54, in the same order as the set aliases. Each one clears exactly the bits written as 1.
- R6: When a clear write and a new event hit the same pending bit in the same cycle, the bit ends set. Any event pulse sets its bit on the next clock edge.
- R7: 0x38 reads the endpoint pending AND the endpoint mask. 0x58 reads the core pending AND the core mask.
- R8: `irq_o` rises on the clock edge after any masked bit becomes nonzero, provided the end-of-interrupt gate is armed. It stays high while a masked bit remains nonzero.
- R9: After `irq_o` has been high, it cannot rise again until a write to 0x60. A write to 0x60 forces `irq_o` low for one cycle, after which the line follows the masked bits again.
- R10: Writing 1 to bit 0 of 0x04 clears both pending words and both masks, drops `irq_o` and re-arms the gate. The same state holds after `rst_n`.
- R11: Writes to the pending offsets 0x20 and 0x40, the mask offsets 0x2C and 0x4C, the masked views, and the reserved offsets leave all state unchanged.
- R12: Software can force the drive-VBUS change event (core bit 24) by writing it through the core set alias at 0x44.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| ep_evt_i | input | 32 | Endpoint event pulses, in the same bit layout as the endpoint pending word |
| core_evt_i | input | 9 | Core USB event pulses |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets the hazards a broken wrapper would show. If bit 16 or a core bit outside 24:16 were not masked, a set-all write would read back a nonzero value there. If a clear were ordered after an event in the same cycle, the event would be lost. If a set or clear alias wrote the whole word instead of only its 1 bits, the other stored bits would change. The interrupt gate is checked in two cases: the line must stay low after a fall until end-of-interrupt, and an end-of-interrupt written with sources still pending must give a one-cycle dip and not a stuck-low or stuck-high line. A design that ignored the soft-reset bit or the gate state would fail the reset readback.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

    localparam int DW = 32;
    localparam int AW = 8;

    typedef logic [DW-1:0] word_t;
    typedef logic [AW-1:0] addr_t;

    // Register byte offsets
    localparam addr_t OFS_REV       = 8'h00;
    localparam addr_t OFS_CTRL      = 8'h04;
    localparam addr_t OFS_STAT      = 8'h08;
    localparam addr_t OFS_EP_PEND   = 8'h20;
    localparam addr_t OFS_EP_PSET   = 8'h24;
    localparam addr_t OFS_EP_PCLR   = 8'h28;
    localparam addr_t OFS_EP_EN     = 8'h2C;
    localparam addr_t OFS_EP_ESET   = 8'h30;
    localparam addr_t OFS_EP_ECLR   = 8'h34;
    localparam addr_t OFS_EP_MASKED = 8'h38;
    localparam addr_t OFS_CR_PEND   = 8'h40;
    localparam addr_t OFS_CR_PSET   = 8'h44;
    localparam addr_t OFS_CR_PCLR   = 8'h48;
    localparam addr_t OFS_CR_EN     = 8'h4C;
    localparam addr_t OFS_CR_ESET   = 8'h50;
    localparam addr_t OFS_CR_ECLR   = 8'h54;
    localparam addr_t OFS_CR_MASKED = 8'h58;
    localparam addr_t OFS_EOI       = 8'h60;

    // Write strobes delivered to one pending/enable bank
    typedef struct packed {
        logic pend_set;
        logic pend_clr;
        logic en_set;
        logic en_clr;
    } bank_wr_t;

    // Valid bits of the endpoint word: TX 0..n-1 low, RX 1..n-1 above
    function automatic word_t ep_valid(input int n);
        logic [63:0] tx;
        logic [63:0] rx;
        tx = (64'd1 << n) - 64'd1;
        rx = ((64'd1 << n) - 64'd2) << n;
        return word_t'(tx | rx);
    endfunction

    function automatic word_t field_valid(input int width, input int lsb);
        logic [63:0] f;
        f = ((64'd1 << width) - 64'd1) << lsb;
        return word_t'(f);
    endfunction

endpackage

// File: rtl/usbirq_bank.sv
module usbirq_bank
    import usbirq_pkg::*;
#(
    parameter word_t VALID = '1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     soft_clr,
    input  bank_wr_t wr,
    input  word_t    wdata,
    input  word_t    evt,
    output word_t    pend_o,
    output word_t    en_o
);

    typedef struct packed {
        word_t pend;
        word_t en;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr.pend_clr) st_d.pend = st_d.pend & ~wdata;
        if (wr.pend_set) st_d.pend = st_d.pend | wdata;
        // events applied last so a same-cycle clear cannot drop them
        st_d.pend = st_d.pend | evt;
        if (wr.en_clr)   st_d.en   = st_d.en & ~wdata;
        if (wr.en_set)   st_d.en   = st_d.en | wdata;
        st_d.pend = st_d.pend & VALID;
        st_d.en   = st_d.en & VALID;
        if (soft_clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;

endmodule

// File: rtl/usbirq_gate.sv
module usbirq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic eoi_we,
    input  logic pending,
    output logic irq_o
);

    typedef struct packed {
        logic armed;
        logic line;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_clr || eoi_we) begin
            st_d.armed = 1'b1;
            st_d.line  = 1'b0;
        end else if (st_q.line) begin
            // line has fired: hold while pending, no re-rise until EOI
            st_d.armed = 1'b0;
            st_d.line  = pending;
        end else begin
            st_d.line = st_q.armed & pending;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b1, line: 1'b0};
        else        st_q <= st_d;
    end

    assign irq_o = st_q.line;

endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
    import usbirq_pkg::*;
#(
    parameter int    NUM_EP   = 16,
    parameter int    CORE_W   = 9,
    parameter int    CORE_LSB = 16,
    parameter word_t REV_ID   = 32'h5EC0_0102
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic [DW-1:0]     ep_evt_i,
    input  logic [CORE_W-1:0] core_evt_i,
    output logic              irq_o
);

    localparam word_t EP_VALID = ep_valid(NUM_EP);
    localparam word_t CR_VALID = field_valid(CORE_W, CORE_LSB);

    logic     soft_clr;
    logic     eoi_we;
    bank_wr_t ep_wr, cr_wr;
    word_t    ep_pend, ep_en, cr_pend, cr_en;
    word_t    cr_evt_word;
    logic     any_pending;

    always_comb begin
        soft_clr = we_i && (addr_i == OFS_CTRL) && wdata_i[0];
        eoi_we   = we_i && (addr_i == OFS_EOI);
        ep_wr.pend_set = we_i && (addr_i == OFS_EP_PSET);
        ep_wr.pend_clr = we_i && (addr_i == OFS_EP_PCLR);
        ep_wr.en_set   = we_i && (addr_i == OFS_EP_ESET);
        ep_wr.en_clr   = we_i && (addr_i == OFS_EP_ECLR);
        cr_wr.pend_set = we_i && (addr_i == OFS_CR_PSET);
        cr_wr.pend_clr = we_i && (addr_i == OFS_CR_PCLR);
        cr_wr.en_set   = we_i && (addr_i == OFS_CR_ESET);
        cr_wr.en_clr   = we_i && (addr_i == OFS_CR_ECLR);
        cr_evt_word    = word_t'(core_evt_i) << CORE_LSB;
    end

    usbirq_bank #(.VALID(EP_VALID)) u_ep_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .wr       (ep_wr),
        .wdata    (wdata_i),
        .evt      (ep_evt_i),
        .pend_o   (ep_pend),
        .en_o     (ep_en)
    );

    usbirq_bank #(.VALID(CR_VALID)) u_cr_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .wr       (cr_wr),
        .wdata    (wdata_i),
        .evt      (cr_evt_word),
        .pend_o   (cr_pend),
        .en_o     (cr_en)
    );

    assign any_pending = |(ep_pend & ep_en) || |(cr_pend & cr_en);

    usbirq_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .eoi_we   (eoi_we),
        .pending  (any_pending),
        .irq_o    (irq_o)
    );

    always_comb begin
        unique case (addr_i)
            OFS_REV:       rdata_o = REV_ID;
            OFS_EP_PEND:   rdata_o = ep_pend;
            OFS_EP_EN:     rdata_o = ep_en;
            OFS_EP_MASKED: rdata_o = ep_pend & ep_en;
            OFS_CR_PEND:   rdata_o = cr_pend;
            OFS_CR_EN:     rdata_o = cr_en;
            OFS_CR_MASKED: rdata_o = cr_pend & cr_en;
            default:       rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/usb_irq_wrap_chk.sv
module usb_irq_wrap_chk
    import usbirq_pkg::*;
#(
    parameter word_t EP_VALID = 32'hFFFE_FFFF,
    parameter word_t CR_VALID = 32'h01FF_0000
) (
    input logic  clk,
    input logic  rst_n,
    input logic  we_i,
    input addr_t addr_i,
    input word_t wdata_i,
    input word_t rdata_o,
    input word_t ep_evt_i,
    input logic  irq_o,
    input word_t ep_pend,
    input word_t ep_en,
    input word_t cr_pend,
    input word_t cr_en
);

    logic fired_q;
    logic rearm_wr;

    assign rearm_wr = we_i && (addr_i == OFS_EOI || (addr_i == OFS_CTRL && wdata_i[0]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        fired_q <= 1'b0;
        else if (rearm_wr) fired_q <= 1'b0;
        else if (irq_o)    fired_q <= 1'b1;
    end

    // R2
    p_ep_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_pend & ~EP_VALID) == '0);

    // R3
    p_core_field_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_pend & ~CR_VALID) == '0);

    // R6
    p_event_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && addr_i == OFS_CTRL && wdata_i[0]) |=>
        ((ep_pend & $past(ep_evt_i & EP_VALID)) == $past(ep_evt_i & EP_VALID)));

    // R7
    p_masked_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == OFS_EP_MASKED) |-> (rdata_o == (ep_pend & ep_en)));

    // R1
    p_alias_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == OFS_EP_PSET || addr_i == OFS_CR_PCLR || addr_i == OFS_EOI) |-> (rdata_o == '0));

    // R8
    p_irq_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|(ep_pend & ep_en) || |(cr_pend & cr_en)));

    // R9
    p_no_rearm_without_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !fired_q);

    // R9
    p_eoi_dip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == OFS_EOI) |=> !irq_o);

endmodule

bind usb_irq_wrap usb_irq_wrap_chk #(
    .EP_VALID(EP_VALID),
    .CR_VALID(CR_VALID)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ep_evt_i(ep_evt_i),
    .irq_o   (irq_o),
    .ep_pend (ep_pend),
    .ep_en   (ep_en),
    .cr_pend (cr_pend),
    .cr_en   (cr_en)
);

// File: tb/sim_usb_irq_wrap.sv
`timescale 1ns/1ps
module sim_usb_irq_wrap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] ep_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    usb_irq_wrap u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (we),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .ep_evt_i  (ep_evt),
        .core_evt_i(core_evt),
        .irq_o     (irq)
    );

    // {is_write, offset, data, expected read, requirement number}
    localparam int NV = 30;
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 8'h00, 32'h0, 32'h5EC0_0102, 8'd1},   // R1 revision
        {1'b0, 8'h20, 32'h0, 32'h0000_0000, 8'd10},  // R10 reset state
        {1'b0, 8'h40, 32'h0, 32'h0000_0000, 8'd10},
        {1'b0, 8'h2C, 32'h0, 32'h0000_0000, 8'd10},
        {1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0, 8'd4},   // R4
        {1'b0, 8'h20, 32'h0, 32'hFFFE_FFFF, 8'd2},   // R2 bit 16 stays 0
        {1'b1, 8'h28, 32'h0000_00F0, 32'h0, 8'd5},   // R5
        {1'b0, 8'h20, 32'h0, 32'hFFFE_FF0F, 8'd5},
        {1'b1, 8'h44, 32'hFFFF_FFFF, 32'h0, 8'd4},
        {1'b0, 8'h40, 32'h0, 32'h01FF_0000, 8'd3},   // R3 field only
        {1'b1, 8'h48, 32'h00FF_0000, 32'h0, 8'd5},
        {1'b0, 8'h40, 32'h0, 32'h0100_0000, 8'd5},
        {1'b1, 8'h30, 32'h0000_FFFF, 32'h0, 8'd4},
        {1'b0, 8'h2C, 32'h0, 32'h0000_FFFF, 8'd4},
        {1'b0, 8'h38, 32'h0, 32'h0000_FF0F, 8'd7},   // R7
        {1'b1, 8'h34, 32'h0000_0F00, 32'h0, 8'd5},
        {1'b0, 8'h2C, 32'h0, 32'h0000_F0FF, 8'd5},
        {1'b0, 8'h38, 32'h0, 32'h0000_F00F, 8'd7},
        {1'b1, 8'h2C, 32'hFFFF_FFFF, 32'h0, 8'd11},  // R11
        {1'b0, 8'h2C, 32'h0, 32'h0000_F0FF, 8'd11},
        {1'b1, 8'h20, 32'h0000_0000, 32'h0, 8'd11},
        {1'b0, 8'h20, 32'h0, 32'hFFFE_FF0F, 8'd11},
        {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 8'd11},
        {1'b0, 8'h10, 32'h0, 32'h0000_0000, 8'd1},
        {1'b0, 8'h24, 32'h0, 32'h0000_0000, 8'd1},
        {1'b0, 8'h5C, 32'h0, 32'h0000_0000, 8'd1},
        {1'b0, 8'h04, 32'h0, 32'h0000_0000, 8'd1},
        {1'b1, 8'h50, 32'hFFFF_FFFF, 32'h0, 8'd4},
        {1'b0, 8'h4C, 32'h0, 32'h01FF_0000, 8'd4},
        {1'b0, 8'h58, 32'h0, 32'h0100_0000, 8'd7}
    };

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #1;
        check(rdata, exp, req);
    endtask

    task automatic pulse_ep(input logic [31:0] v);
        @(negedge clk); ep_evt = v;
        @(negedge clk); ep_evt = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check({31'b0, irq}, 32'h0, "R10 irq after reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][80]) begin
                wr(VEC[i][79:72], VEC[i][71:40]);
            end else begin
                rd_chk(VEC[i][79:72], VEC[i][39:8], $sformatf("R%0d vec %0d", VEC[i][7:0], i));
            end
        end

        // R10 soft reset
        wr(8'h04, 32'h1);
        rd_chk(8'h20, 32'h0, "R10 ep pend");
        rd_chk(8'h2C, 32'h0, "R10 ep en");
        rd_chk(8'h40, 32'h0, "R10 core pend");
        rd_chk(8'h4C, 32'h0, "R10 core en");
        check({31'b0, irq}, 32'h0, "R10 irq");

        // R8 latency and level
        wr(8'h30, 32'h1);
        pulse_ep(32'h1);
        check({31'b0, irq}, 32'h0, "R8 not yet");
        @(negedge clk);
        check({31'b0, irq}, 32'h1, "R8 raised");
        repeat (3) @(negedge clk);
        check({31'b0, irq}, 32'h1, "R8 held");

        // R9 fall, no re-rise until EOI
        wr(8'h28, 32'h1);
        repeat (2) @(negedge clk);
        check({31'b0, irq}, 32'h0, "R9 fell");
        pulse_ep(32'h1);
        repeat (3) @(negedge clk);
        check({31'b0, irq}, 32'h0, "R9 gated");
        rd_chk(8'h38, 32'h1, "R9 pending visible");
        wr(8'h60, 32'h0);
        check({31'b0, irq}, 32'h0, "R9 eoi edge");
        @(negedge clk);
        check({31'b0, irq}, 32'h1, "R9 re-raised");
        wr(8'h60, 32'h0);
        check({31'b0, irq}, 32'h0, "R9 dip");
        @(negedge clk);
        check({31'b0, irq}, 32'h1, "R9 back");

        // R6 clear and event same cycle
        @(negedge clk);
        we = 1'b1; addr = 8'h28; wdata = 32'h20; ep_evt = 32'h20;
        @(negedge clk);
        we = 1'b0; wdata = '0; ep_evt = '0;
        rd_chk(8'h20, 32'h21, "R6 event wins");
        wr(8'h28, 32'h20);
        rd_chk(8'h20, 32'h1, "R5 plain clear");

        // R2 receive bit and unused bit 16
        pulse_ep(32'h0003_0000);
        rd_chk(8'h20, 32'h0002_0001, "R2 rx ep1");

        // R3 core event mapping
        @(negedge clk); core_evt = 9'h008;
        @(negedge clk); core_evt = '0;
        rd_chk(8'h40, 32'h0008_0000, "R3 core evt3");

        // R12 force drive-VBUS event
        wr(8'h44, 32'h0100_0000);
        rd_chk(8'h40, 32'h0108_0000, "R12 forced");
        wr(8'h50, 32'h0100_0000);
        rd_chk(8'h58, 32'h0100_0000, "R12 masked");

        done = 1'b1;
        summary();
    end

endmodule